// File: doc/BRIEF.md
# Serial Flash Identity and Capacity Probe

This block drives an attached serial data flash in SPI mode 0 and works out what part is fitted. A one-cycle `start` pulse launches two back-to-back commands. The first is an information read that returns a manufacturer byte, a density code, an auxiliary byte and a length byte. The length byte says how many extension bytes follow, and the block reads exactly that many of them, up to a parameter limit. After chip select has stayed high for an idle gap, the block sends a status read and takes one status byte.

The block then decodes two independent density encodings, one from the identification bytes and one from the status byte. It also extracts the page-size and protection bits and computes the array capacity in bits. All results are presented together with a one-cycle `done` pulse. A host uses the results to tell apart flash revisions that share every other identifier. A mismatch between the two encodings, or a size code that the block does not recognise, is reported through `err`. The run still completes normally in that case.

Top module: `flash_id_probe`

## Requirements
- R1: A `start` pulse while idle pulls `cs_n` low and shifts out opcode 0x9F MSB first in SPI mode 0. In this mode `sck` idles low, `mosi` changes only while `sck` is low, and `miso` is sampled on the rising edge. Each `sck` half-period is `DIV` clock cycles.
- R2: After 0x9F the block reads exactly 4 + min(L, `EDI_MAX`) bytes, where L is the fourth returned byte. Returned bytes 0, 2 and 3 appear on `mfr_id`, `dev_aux` and `edi_len`.
- R3: Extension byte k (k counted from 0) appears on `edi_data[8k+7:8k]`. Slots that were not read in the current run are zero.
- R4: Between the two commands `cs_n` stays high for at least 2×`DIV` clock cycles. The block then sends status opcode 0xD7 (0x57 when `LEGACY_STATUS`=1) and reads one byte.
- R5: `st_size` decodes status bits [5:2]: 0011→1 (1 Mb), 0101→2 (2 Mb), 0111→3 (4 Mb), 1001→4 (8 Mb), 1011→5 (16 Mb). Any other code gives 0.
- R6: `id_size` decodes returned byte 1 as follows: values 0x22 to 0x26 give 1 to 5, in the same size order as R5. Any other value gives 0.
- R7: `err` is 1 when `st_size` is 0 or when `st_size` differs from `id_size`. `done` is still produced in either case.
- R8: `page_pow2` equals status bit 0 (1 = 256-byte pages, 0 = 264-byte pages). `sect_prot` equals status bit 1.
- R9: `cap_bits` is 2^(st_size−1) × U, where U is 1,048,576 when `page_pow2`=1 and 1,081,344 when `page_pow2`=0. It is 0 when `st_size` is 0.
- R10: `done` is a one-cycle pulse, and `busy` falls in that same cycle. `cs_n` is low only while `busy` is high.
- R11: A `start` pulse while `busy` is high is ignored: each accepted run makes exactly two chip-select transactions.
- R12: After reset, `cs_n`=1, `sck`=0, `busy`=0, `done`=0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a probe run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: results valid |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| mfr_id | output | 8 | Returned ID byte 0 |
| dev_dens | output | 8 | Returned ID byte 1 (density code) |
| dev_aux | output | 8 | Returned ID byte 2 |
| edi_len | output | 8 | Returned ID byte 3 (extension length) |
| edi_data | output | 8×EDI_MAX | Captured extension bytes |
| id_size | output | 3 | Size index from ID byte 1 |
| st_size | output | 3 | Size index from status bits [5:2] |
| page_pow2 | output | 1 | Power-of-two page mode |
| sect_prot | output | 1 | Sector protection flag |
| cap_bits | output | 32 | Array capacity in bits |
| err | output | 1 | Unknown size or density disagreement |

## Verification
The hardest situation to reach is an extension length above `EDI_MAX`. In that case the block must stop reading after the capped count even though the flash keeps returning bytes. The bench's flash model counts rising `sck` edges per transaction and serves any number of extension bytes, so a length of 3 against a limit of 2 shows up directly as the edge count. The bench sweeps all sixteen status size codes against extension lengths 0 to 3. It mixes in ID codes that are deliberately mismatched or out of range, and it sends one extra `start` pulse in the middle of a run.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;
   localparam logic [7:0] OP_INFO       = 8'h9F;
   localparam logic [7:0] OP_STAT       = 8'hD7;
   localparam logic [7:0] OP_STAT_OLD   = 8'h57;
   localparam logic [7:0] ID_DENS_FIRST = 8'h22;
   localparam logic [7:0] ID_DENS_LAST  = 8'h26;
   localparam logic [31:0] UNIT_POW2    = 32'd1048576;
   localparam logic [31:0] UNIT_EXT     = 32'd1081344;

   typedef enum logic [2:0] {
      S_IDLE, S_ID_OP, S_ID_RD, S_GAP, S_ST_OP, S_ST_RD, S_WRAP, S_DONE
   } probe_state_t;
endpackage

// File: rtl/fid_spi_shifter.sv
module fid_spi_shifter #(
   parameter int DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] tx,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic [7:0] rx,
   output logic       fin
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [CW-1:0] cnt;
   logic [2:0]    bitn;
   logic          act;
   logic [7:0]    osh;
   logic [7:0]    ish;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         bitn <= '0;
         act  <= 1'b0;
         osh  <= '0;
         ish  <= '0;
         sck  <= 1'b0;
         fin  <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go && !act) begin
            act  <= 1'b1;
            osh  <= tx;
            cnt  <= '0;
            bitn <= '0;
            sck  <= 1'b0;
         end else if (act) begin
            if (cnt == CW'(DIV - 1)) begin
               cnt <= '0;
               if (!sck) begin
                  sck <= 1'b1;
                  ish <= {ish[6:0], miso};
               end else begin
                  sck <= 1'b0;
                  if (bitn == 3'd7) begin
                     act <= 1'b0;
                     fin <= 1'b1;
                  end else begin
                     bitn <= bitn + 3'd1;
                     osh  <= {osh[6:0], 1'b0};
                  end
               end
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   end

   assign mosi = osh[7];
   assign rx   = ish;
endmodule

// File: rtl/fid_sequencer.sv
module fid_sequencer
   import flash_id_pkg::*;
#(
   parameter int DIV     = 2,
   parameter int EDI_MAX = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [7:0]         st_op,
   output logic               busy,
   output logic               cs_n,
   output logic               go,
   output logic [7:0]         tx,
   input  logic               fin,
   input  logic [7:0]         rx,
   output logic               cap_en,
   output logic [7:0]         id_b0,
   output logic [7:0]         id_b1,
   output logic [7:0]         id_b2,
   output logic [7:0]         id_b3,
   output logic [8*EDI_MAX-1:0] edi_flat,
   output logic [5:0]         stat_q
);
   localparam int IW  = $clog2(EDI_MAX + 5);
   localparam int GAP = 2 * DIV;
   localparam int GW  = $clog2(GAP + 1);

   probe_state_t   state;
   logic [IW-1:0]  idx;
   logic [IW-1:0]  need;
   logic [GW-1:0]  gcnt;
   logic [7:0]     edi_q [EDI_MAX];
   logic [IW-1:0]  len_cap;

   always_comb begin
      if (rx > 8'(EDI_MAX)) len_cap = IW'(EDI_MAX);
      else                  len_cap = IW'(rx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         idx    <= '0;
         need   <= '0;
         gcnt   <= '0;
         busy   <= 1'b0;
         cs_n   <= 1'b1;
         go     <= 1'b0;
         tx     <= '0;
         cap_en <= 1'b0;
         id_b0  <= '0;
         id_b1  <= '0;
         id_b2  <= '0;
         id_b3  <= '0;
         stat_q <= '0;
         for (int k = 0; k < EDI_MAX; k++) edi_q[k] <= '0;
      end else begin
         go     <= 1'b0;
         cap_en <= 1'b0;
         case (state)
            S_IDLE: if (start) begin
               busy  <= 1'b1;
               cs_n  <= 1'b0;
               go    <= 1'b1;
               tx    <= OP_INFO;
               idx   <= '0;
               need  <= '0;
               for (int k = 0; k < EDI_MAX; k++) edi_q[k] <= '0;
               state <= S_ID_OP;
            end
            S_ID_OP: if (fin) begin
               go    <= 1'b1;
               tx    <= 8'h00;
               state <= S_ID_RD;
            end
            S_ID_RD: if (fin) begin
               case (idx)
                  IW'(0): id_b0 <= rx;
                  IW'(1): id_b1 <= rx;
                  IW'(2): id_b2 <= rx;
                  IW'(3): id_b3 <= rx;
                  default: ;
               endcase
               for (int k = 0; k < EDI_MAX; k++)
                  if (idx == IW'(4 + k)) edi_q[k] <= rx;
               if ((idx == IW'(3) && len_cap == '0) ||
                   (idx > IW'(3) && idx == need + IW'(3))) begin
                  cs_n  <= 1'b1;
                  gcnt  <= '0;
                  state <= S_GAP;
               end else begin
                  if (idx == IW'(3)) need <= len_cap;
                  idx <= idx + IW'(1);
                  go  <= 1'b1;
               end
            end
            S_GAP: begin
               if (gcnt == GW'(GAP - 1)) begin
                  cs_n  <= 1'b0;
                  go    <= 1'b1;
                  tx    <= st_op;
                  state <= S_ST_OP;
               end else begin
                  gcnt <= gcnt + GW'(1);
               end
            end
            S_ST_OP: if (fin) begin
               go    <= 1'b1;
               tx    <= 8'h00;
               state <= S_ST_RD;
            end
            S_ST_RD: if (fin) begin
               stat_q <= rx[5:0];
               cs_n   <= 1'b1;
               state  <= S_WRAP;
            end
            S_WRAP: begin
               cap_en <= 1'b1;
               state  <= S_DONE;
            end
            S_DONE: begin
               busy  <= 1'b0;
               state <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   for (genvar k = 0; k < EDI_MAX; k++) begin : g_edi
      assign edi_flat[8*k +: 8] = edi_q[k];
   end
endmodule

// File: rtl/fid_decode.sv
module fid_decode
   import flash_id_pkg::*;
(
   input  logic [7:0]  dens_code,
   input  logic [5:0]  stat,
   output logic [2:0]  id_idx,
   output logic [2:0]  st_idx,
   output logic        err,
   output logic [31:0] cap
);
   logic [3:0]  sz;
   logic [31:0] unit;

   assign sz = stat[5:2];

   always_comb begin
      case (sz)
         4'b0011: st_idx = 3'd1;
         4'b0101: st_idx = 3'd2;
         4'b0111: st_idx = 3'd3;
         4'b1001: st_idx = 3'd4;
         4'b1011: st_idx = 3'd5;
         default: st_idx = 3'd0;
      endcase
      if (dens_code >= ID_DENS_FIRST && dens_code <= ID_DENS_LAST)
         id_idx = 3'(dens_code - ID_DENS_FIRST + 8'd1);
      else
         id_idx = 3'd0;
      err  = (st_idx == 3'd0) || (st_idx != id_idx);
      unit = stat[0] ? UNIT_POW2 : UNIT_EXT;
      cap  = (st_idx == 3'd0) ? 32'd0 : (unit << (st_idx - 3'd1));
   end
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
   import flash_id_pkg::*;
#(
   parameter int DIV           = 2,
   parameter int EDI_MAX       = 2,
   parameter bit LEGACY_STATUS = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   output logic                 busy,
   output logic                 done,
   output logic                 sck,
   output logic                 cs_n,
   output logic                 mosi,
   input  logic                 miso,
   output logic [7:0]           mfr_id,
   output logic [7:0]           dev_dens,
   output logic [7:0]           dev_aux,
   output logic [7:0]           edi_len,
   output logic [8*EDI_MAX-1:0] edi_data,
   output logic [2:0]           id_size,
   output logic [2:0]           st_size,
   output logic                 page_pow2,
   output logic                 sect_prot,
   output logic [31:0]          cap_bits,
   output logic                 err
);
   if (DIV < 1 || DIV > 1024) begin : g_bad_div
      $error("flash_id_probe: DIV out of range");
   end
   if (EDI_MAX < 1 || EDI_MAX > 8) begin : g_bad_edi
      $error("flash_id_probe: EDI_MAX out of range");
   end

   logic [7:0] st_op;
   if (LEGACY_STATUS) begin : g_stat_old
      assign st_op = OP_STAT_OLD;
   end else begin : g_stat_new
      assign st_op = OP_STAT;
   end

   logic                 go, fin, cap_en;
   logic [7:0]           tx, rx;
   logic [7:0]           b0, b1, b2, b3;
   logic [8*EDI_MAX-1:0] edi_flat;
   logic [5:0]           stat_q;
   logic [2:0]           id_idx, st_idx;
   logic                 dec_err;
   logic [31:0]          dec_cap;

   fid_spi_shifter #(.DIV(DIV)) i_shift (
      .clk(clk), .rst_n(rst_n), .go(go), .tx(tx), .miso(miso),
      .sck(sck), .mosi(mosi), .rx(rx), .fin(fin)
   );

   fid_sequencer #(.DIV(DIV), .EDI_MAX(EDI_MAX)) i_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .st_op(st_op),
      .busy(busy), .cs_n(cs_n), .go(go), .tx(tx), .fin(fin), .rx(rx),
      .cap_en(cap_en), .id_b0(b0), .id_b1(b1), .id_b2(b2), .id_b3(b3),
      .edi_flat(edi_flat), .stat_q(stat_q)
   );

   fid_decode i_dec (
      .dens_code(b1), .stat(stat_q), .id_idx(id_idx), .st_idx(st_idx),
      .err(dec_err), .cap(dec_cap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done      <= 1'b0;
         mfr_id    <= '0;
         dev_dens  <= '0;
         dev_aux   <= '0;
         edi_len   <= '0;
         edi_data  <= '0;
         id_size   <= '0;
         st_size   <= '0;
         page_pow2 <= 1'b0;
         sect_prot <= 1'b0;
         cap_bits  <= '0;
         err       <= 1'b0;
      end else begin
         done <= cap_en;
         if (cap_en) begin
            mfr_id    <= b0;
            dev_dens  <= b1;
            dev_aux   <= b2;
            edi_len   <= b3;
            edi_data  <= edi_flat;
            id_size   <= id_idx;
            st_size   <= st_idx;
            page_pow2 <= stat_q[0];
            sect_prot <= stat_q[1];
            cap_bits  <= dec_cap;
            err       <= dec_err;
         end
      end
   end
endmodule

// File: rtl/fid_probe_checks.sv
module fid_probe_checks (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       busy,
   input logic       done,
   input logic       sck,
   input logic       cs_n,
   input logic [2:0] id_size,
   input logic [2:0] st_size,
   input logic       err
);
   p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);

   p_cs_in_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n);

   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_drops_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_unknown_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && st_size == 3'd0) |-> err);

   p_disagree_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && st_size != id_size) |-> err);

   p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));
endmodule

bind flash_id_probe fid_probe_checks i_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .sck(sck), .cs_n(cs_n), .id_size(id_size), .st_size(st_size), .err(err)
);

// File: tb/test_flash_id_probe.sv
module test_flash_id_probe;
   localparam int DIV  = 2;
   localparam int EMAX = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic busy, done, sck, cs_n, mosi;
   logic miso = 1'b0;
   logic [7:0] mfr_id, dev_dens, dev_aux, edi_len;
   logic [8*EMAX-1:0] edi_data;
   logic [2:0] id_size, st_size;
   logic page_pow2, sect_prot, err;
   logic [31:0] cap_bits;

   always #2 clk = ~clk;

   flash_id_probe #(.DIV(DIV), .EDI_MAX(EMAX), .LEGACY_STATUS(1'b0)) i_flash_id_probe (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
      .mfr_id(mfr_id), .dev_dens(dev_dens), .dev_aux(dev_aux), .edi_len(edi_len),
      .edi_data(edi_data), .id_size(id_size), .st_size(st_size),
      .page_pow2(page_pow2), .sect_prot(sect_prot), .cap_bits(cap_bits), .err(err)
   );

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;
   bit finished = 0;

   always @(posedge clk) cyc++;

   // flash model
   logic [7:0] id_arr [0:7];
   logic [7:0] st_val;
   logic [7:0] cmd;
   int nrise, txn, c1, r1, c2, r2, rise_cyc, gap;

   always @(negedge cs_n) begin
      nrise = 0;
      cmd = 8'h00;
      miso = 1'b0;
      if (txn > 0) gap = cyc - rise_cyc;
   end
   always @(posedge sck) if (!cs_n) begin
      if (nrise < 8) cmd = {cmd[6:0], mosi};
      nrise++;
   end
   always @(negedge sck) if (!cs_n && nrise >= 8) begin
      logic [7:0] b;
      int bi;
      bi = (nrise - 8) / 8;
      if (cmd == 8'h9F)      b = (bi < 8) ? id_arr[bi] : 8'h00;
      else if (cmd == 8'hD7) b = st_val;
      else                   b = 8'hFF;
      miso = b[7 - ((nrise - 8) % 8)];
   end
   always @(posedge cs_n) begin
      txn++;
      rise_cyc = cyc;
      if (txn == 1) begin c1 = int'(cmd); r1 = nrise; end
      if (txn == 2) begin c2 = int'(cmd); r2 = nrise; end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run_one(input int st, input int len, input int idb, input bit extra_start);
      int exp_st, exp_id, ncap;
      bit pg, pr, got;
      logic [31:0] exp_cap;
      logic [8*EMAX-1:0] exp_edi;
      pg = st[0] ^ len[0];
      pr = len[1];
      id_arr[0] = 8'h1F;
      id_arr[1] = 8'(idb);
      id_arr[2] = 8'(8'h5A ^ st);
      id_arr[3] = 8'(len);
      for (int k = 4; k < 8; k++) id_arr[k] = 8'(8'hA0 + k - 4);
      st_val = {1'b1, 1'b0, 4'(st), pr, pg};
      txn = 0; c1 = 0; c2 = 0; r1 = 0; r2 = 0; gap = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk("R10 busy after start", 32'(busy), 32'd1);
      got = 0;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (extra_start && i == 60) start = 1'b1;
         if (extra_start && i == 61) start = 1'b0;
         if (done) begin got = 1; break; end
      end
      chk("R10 done seen (watchdog)", 32'(got), 32'd1);
      if (!got) return;
      exp_st = (st[0] && st >= 3 && st <= 11) ? (st - 1) / 2 : 0;
      exp_id = (idb >= 8'h22 && idb <= 8'h26) ? idb - 8'h21 : 0;
      ncap = (len > EMAX) ? EMAX : len;
      exp_edi = '0;
      for (int k = 0; k < EMAX; k++)
         if (k < ncap) exp_edi[8*k +: 8] = 8'(8'hA0 + k);
      exp_cap = (exp_st == 0) ? 32'd0 : ((pg ? 32'd1048576 : 32'd1081344) << (exp_st - 1));
      chk("R10 busy low at done", 32'(busy), 32'd0);
      chk("R10 cs_n high at done", 32'(cs_n), 32'd1);
      chk("R1 info opcode", 32'(c1), 32'h9F);
      chk("R2 info edges", 32'(r1), 32'(8 * (5 + ncap)));
      chk("R2 mfr byte", 32'(mfr_id), 32'h1F);
      chk("R2 aux byte", 32'(dev_aux), 32'(8'(8'h5A ^ st)));
      chk("R2 length byte", 32'(edi_len), 32'(len));
      chk("R3 ext bytes", 32'(edi_data), 32'(exp_edi));
      chk("R4 status opcode", 32'(c2), 32'hD7);
      chk("R4 status edges", 32'(r2), 32'd16);
      chk("R4 gap", 32'(gap >= 2 * DIV), 32'd1);
      chk("R5 status size", 32'(st_size), 32'(exp_st));
      chk("R6 id size", 32'(id_size), 32'(exp_id));
      chk("R6 density byte", 32'(dev_dens), 32'(idb));
      chk("R7 err", 32'(err), 32'((exp_st == 0) || (exp_st != exp_id)));
      chk("R8 page mode", 32'(page_pow2), 32'(pg));
      chk("R8 protect", 32'(sect_prot), 32'(pr));
      chk("R9 capacity", cap_bits, exp_cap);
      @(negedge clk);
      chk("R10 done single", 32'(done), 32'd0);
      repeat (40) @(negedge clk);
      chk("R11 two transactions", 32'(txn), 32'd2);
      chk("R11 idle after run", 32'(busy), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R12 cs_n", 32'(cs_n), 32'd1);
      chk("R12 sck", 32'(sck), 32'd0);
      chk("R12 busy", 32'(busy), 32'd0);
      chk("R12 done", 32'(done), 32'd0);
      chk("R12 results", {cap_bits[15:0], mfr_id, 5'(0), st_size}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R12 idle after release", 32'(cs_n), 32'd1);
      for (int st = 0; st < 16; st++) begin
         for (int len = 0; len < 4; len++) begin
            int es, idb;
            es = (st[0] && st >= 3 && st <= 11) ? (st - 1) / 2 : 0;
            if (st == 9 && len == 2)          idb = 8'h30;
            else if (es == 0)                  idb = 8'h22 + len;
            else if (((st + len) % 5) == 2)    idb = 8'h21 + (es % 5) + 1;
            else                               idb = 8'h21 + es;
            run_one(st, len, idb, (st == 5 && len == 3));
         end
      end
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog R10 actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule